// File: doc/BRIEF.md
# Integer Execute Unit with Rotate

This block is the integer execute stage of a 32-bit load/store style core. Each cycle it may accept one decoded instruction: the 6-bit major opcode, the 5-bit first-source-register field (which also selects rotate for one shift form), the low 16 instruction bits (immediate, shift amount and function code), the two source operand values and the destination register index. It computes the result combinationally and registers it with a write-enable, the destination index and an illegal-operation flag. Results are visible one clock after the instruction is presented.

The unit covers wrapping add and subtract (register and immediate), the four bitwise operations, signed and unsigned set-less-than, signed min and max, load-upper, conditional moves, and left, logical-right, arithmetic-right and rotate-right shifts by an immediate or register amount. A conditional move whose condition fails produces no write at all, so the register file never needs a read-modify-write path. Overflow traps, the register file and fetch sit outside the block.

Top module: `int_alu`

## Requirements
- R1: Function codes 32 and 33 (major opcode 0) give opa+opb, 34 and 35 give opa-opb, and major opcodes 8 and 9 give opa plus the sign-extended imm_fld; all wrap modulo 2^32 with no trap.
- R2: Function codes 36, 37, 38, 39 give AND, OR, XOR and NOR of opa and opb; major opcodes 12, 13, 14 give AND, OR, XOR of opa with the zero-extended imm_fld.
- R3: Major opcode 15 gives imm_fld in bits 31:16 with bits 15:0 zero.
- R4: Function 42 gives 1 when opa < opb signed, else 0; function 43 the same unsigned; major opcode 10 compares opa signed against the sign-extended imm_fld, and 11 compares unsigned against the sign-extended imm_fld.
- R5: Function 44 gives the signed maximum of opa and opb; function 45 the signed minimum.
- R6: Function 10 writes opa only when opb is zero and function 11 only when opb is non-zero; when the condition fails wr_en_q stays low.
- R7: Functions 0, 2, 3 shift opb left, logically right and arithmetically right by imm_fld[10:6]; function 2 rotates right instead when sel_fld equals 1.
- R8: Functions 4, 6, 7 do the same three shifts by opa[4:0] only (amounts of 32 or more wrap); function 6 rotates right instead when imm_fld[10:6] equals 1.
- R9: When dst_idx is 0 no write takes place (wr_en_q low).
- R10: Any other major opcode, or any other function code under major opcode 0, raises illegal_q and suppresses the write.
- R11: Outputs are registered: they reflect the instruction presented at the previous rising edge; a cycle without in_valid gives wr_en_q and illegal_q low; reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| op_major | input | 6 | Major opcode |
| sel_fld | input | 5 | First-source register field, selects rotate for function 2 |
| imm_fld | input | 16 | Immediate; bits 10:6 shift amount, bits 5:0 function code |
| opa | input | 32 | First source operand value |
| opb | input | 32 | Second source operand value |
| dst_idx | input | 5 | Destination register index |
| res_q | output | 32 | Registered result |
| wr_en_q | output | 1 | Registered write-enable |
| wr_dst_q | output | 5 | Registered destination index |
| illegal_q | output | 1 | Registered unsupported-operation flag |

## Verification
The hardest cases to reach are the rotate variants, since they hide behind a second field that equals exactly 1 while the same function code otherwise means a plain logical right shift; random encodings almost never land there. Directed vectors therefore set the selector field to 1 and to neighbouring values on both the immediate and the register-amount forms, with amounts of 0, 31 and values of 32 or more to hit the wrap. Directed sign boundaries (most negative against -1, the all-ones immediate for unsigned compare) and failing conditional moves follow, and a long run of mixed random encodings is compared every clock against a behavioural model in the bench.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

   typedef enum logic [3:0] {
      K_ADD, K_SUB, K_AND, K_OR, K_XOR, K_NOR, K_SLT, K_SLTU,
      K_MAX, K_MIN, K_LUI, K_SHIFT, K_MOVZ, K_MOVN
   } alu_kind_e;

   typedef enum logic [1:0] {
      SH_LL, SH_RL, SH_RA, SH_RR
   } shift_kind_e;

   typedef struct packed {
      alu_kind_e   kind;
      shift_kind_e sh_kind;
      logic        use_imm;
      logic        imm_sext;
      logic        var_amt;
      logic        illegal;
   } alu_dec_t;

endpackage

// File: rtl/int_alu_decode.sv
module int_alu_decode
   import int_alu_pkg::*;
(
   input  logic [5:0]  op_major,
   input  logic [4:0]  sel_fld,
   input  logic [4:0]  sa_fld,
   input  logic [5:0]  fn_fld,
   output alu_dec_t    dec
);

   always_comb begin
      dec          = '0;
      dec.kind     = K_ADD;
      dec.sh_kind  = SH_LL;
      unique case (op_major)
         6'd0: begin
            unique case (fn_fld)
               6'd0:  dec.kind = K_SHIFT;
               6'd2:  begin
                  dec.kind    = K_SHIFT;
                  dec.sh_kind = (sel_fld == 5'd1) ? SH_RR : SH_RL;
               end
               6'd3:  begin dec.kind = K_SHIFT; dec.sh_kind = SH_RA; end
               6'd4:  begin dec.kind = K_SHIFT; dec.var_amt = 1'b1; end
               6'd6:  begin
                  dec.kind    = K_SHIFT;
                  dec.var_amt = 1'b1;
                  dec.sh_kind = (sa_fld == 5'd1) ? SH_RR : SH_RL;
               end
               6'd7:  begin dec.kind = K_SHIFT; dec.sh_kind = SH_RA; dec.var_amt = 1'b1; end
               6'd10: dec.kind = K_MOVZ;
               6'd11: dec.kind = K_MOVN;
               6'd32, 6'd33: dec.kind = K_ADD;
               6'd34, 6'd35: dec.kind = K_SUB;
               6'd36: dec.kind = K_AND;
               6'd37: dec.kind = K_OR;
               6'd38: dec.kind = K_XOR;
               6'd39: dec.kind = K_NOR;
               6'd42: dec.kind = K_SLT;
               6'd43: dec.kind = K_SLTU;
               6'd44: dec.kind = K_MAX;
               6'd45: dec.kind = K_MIN;
               default: dec.illegal = 1'b1;
            endcase
         end
         6'd8, 6'd9: begin dec.kind = K_ADD;  dec.use_imm = 1'b1; dec.imm_sext = 1'b1; end
         6'd10:      begin dec.kind = K_SLT;  dec.use_imm = 1'b1; dec.imm_sext = 1'b1; end
         6'd11:      begin dec.kind = K_SLTU; dec.use_imm = 1'b1; dec.imm_sext = 1'b1; end
         6'd12:      begin dec.kind = K_AND;  dec.use_imm = 1'b1; end
         6'd13:      begin dec.kind = K_OR;   dec.use_imm = 1'b1; end
         6'd14:      begin dec.kind = K_XOR;  dec.use_imm = 1'b1; end
         6'd15:      dec.kind = K_LUI;
         default:    dec.illegal = 1'b1;
      endcase
   end

endmodule

// File: rtl/int_alu_shifter.sv
module int_alu_shifter
   import int_alu_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int SHAMT_W = $clog2(DATA_W)
)(
   input  logic [DATA_W-1:0]  val,
   input  logic [SHAMT_W-1:0] amt,
   input  shift_kind_e        kind,
   output logic [DATA_W-1:0]  res
);

   logic [SHAMT_W:0][DATA_W-1:0] stg;
   logic                         fill;

   assign fill   = (kind == SH_RA) ? val[DATA_W-1] : 1'b0;
   assign stg[0] = val;

   for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
      localparam int S = 1 << k;
      logic [DATA_W-1:0] moved;
      always_comb begin
         unique case (kind)
            SH_LL:   moved = {stg[k][DATA_W-1-S:0], {S{1'b0}}};
            SH_RR:   moved = {stg[k][S-1:0], stg[k][DATA_W-1:S]};
            default: moved = {{S{fill}}, stg[k][DATA_W-1:S]};
         endcase
      end
      assign stg[k+1] = amt[k] ? moved : stg[k];
   end

   assign res = stg[SHAMT_W];

endmodule

// File: rtl/int_alu_core.sv
module int_alu_core
   import int_alu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 16
)(
   input  alu_dec_t          dec,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic [IMM_W-1:0]  imm,
   output logic [DATA_W-1:0] result,
   output logic              cond_ok
);

   localparam int SHAMT_W = $clog2(DATA_W);
   localparam int EXT_W   = DATA_W - IMM_W;

   logic [DATA_W-1:0]  bsel;
   logic [DATA_W-1:0]  sh_res;
   logic [SHAMT_W-1:0] amt;
   logic               lt_s, lt_u;

   always_comb begin
      if (!dec.use_imm)       bsel = opb;
      else if (dec.imm_sext)  bsel = {{EXT_W{imm[IMM_W-1]}}, imm};
      else                    bsel = {{EXT_W{1'b0}}, imm};
   end

   assign amt  = dec.var_amt ? opa[SHAMT_W-1:0] : SHAMT_W'(imm[10:6]);
   assign lt_s = $signed(opa) < $signed(bsel);
   assign lt_u = opa < bsel;

   int_alu_shifter #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shift (
      .val  (opb),
      .amt  (amt),
      .kind (dec.sh_kind),
      .res  (sh_res)
   );

   always_comb begin
      cond_ok = 1'b1;
      unique case (dec.kind)
         K_ADD:   result = opa + bsel;
         K_SUB:   result = opa - bsel;
         K_AND:   result = opa & bsel;
         K_OR:    result = opa | bsel;
         K_XOR:   result = opa ^ bsel;
         K_NOR:   result = ~(opa | bsel);
         K_SLT:   result = DATA_W'(lt_s);
         K_SLTU:  result = DATA_W'(lt_u);
         K_MAX:   result = lt_s ? bsel : opa;
         K_MIN:   result = lt_s ? opa : bsel;
         K_LUI:   result = {imm, {EXT_W{1'b0}}};
         K_SHIFT: result = sh_res;
         K_MOVZ:  begin result = opa; cond_ok = (opb == '0); end
         K_MOVN:  begin result = opa; cond_ok = (opb != '0); end
         default: result = '0;
      endcase
   end

endmodule

// File: rtl/int_alu.sv
module int_alu
   import int_alu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 16,
   parameter int IDX_W  = 5
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [5:0]        op_major,
   input  logic [4:0]        sel_fld,
   input  logic [IMM_W-1:0]  imm_fld,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic [IDX_W-1:0]  dst_idx,
   output logic [DATA_W-1:0] res_q,
   output logic              wr_en_q,
   output logic [IDX_W-1:0]  wr_dst_q,
   output logic              illegal_q
);

   if (DATA_W < 2 * IMM_W) begin : g_bad_width
      $error("int_alu: DATA_W must hold two immediates");
   end
   if ((1 << $clog2(DATA_W)) != DATA_W) begin : g_bad_pow2
      $error("int_alu: DATA_W must be a power of two");
   end
   if (IMM_W != 16) begin : g_bad_imm
      $error("int_alu: immediate field layout needs IMM_W of 16");
   end

   alu_dec_t          dec;
   logic [DATA_W-1:0] result;
   logic              cond_ok;
   logic              do_write;

   int_alu_decode u_dec (
      .op_major (op_major),
      .sel_fld  (sel_fld),
      .sa_fld   (imm_fld[10:6]),
      .fn_fld   (imm_fld[5:0]),
      .dec      (dec)
   );

   int_alu_core #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_core (
      .dec     (dec),
      .opa     (opa),
      .opb     (opb),
      .imm     (imm_fld),
      .result  (result),
      .cond_ok (cond_ok)
   );

   assign do_write = in_valid && !dec.illegal && cond_ok && (dst_idx != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q     <= '0;
         wr_en_q   <= 1'b0;
         wr_dst_q  <= '0;
         illegal_q <= 1'b0;
      end else begin
         res_q     <= result;
         wr_en_q   <= do_write;
         wr_dst_q  <= dst_idx;
         illegal_q <= in_valid && dec.illegal;
      end
   end

endmodule

// File: rtl/int_alu_checker.sv
module int_alu_checker #(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 16,
   parameter int IDX_W  = 5
)(
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [5:0]        op_major,
   input logic [IMM_W-1:0]  imm_fld,
   input logic [DATA_W-1:0] opa,
   input logic [DATA_W-1:0] opb,
   input logic [IDX_W-1:0]  dst_idx,
   input logic [DATA_W-1:0] res_q,
   input logic              wr_en_q,
   input logic [IDX_W-1:0]  wr_dst_q,
   input logic              illegal_q
);

   logic is_r;
   assign is_r = in_valid && (op_major == 6'd0);

   a_r9_no_zero_dest: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_q |-> (wr_dst_q != '0));

   a_r10_illegal_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_q |-> !wr_en_q);

   a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!wr_en_q && !illegal_q));

   a_r3_upper_imm: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_major == 6'd15 && dst_idx != '0) |=>
      (wr_en_q && res_q == {$past(imm_fld), {(DATA_W-IMM_W){1'b0}}}));

   a_r6_movz_fail_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
      (is_r && imm_fld[5:0] == 6'd10 && opb != '0) |=> !wr_en_q);

   a_r6_movn_fail_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
      (is_r && imm_fld[5:0] == 6'd11 && opb == '0) |=> !wr_en_q);

   a_r4_compare_boolean: assert property (@(posedge clk) disable iff (!rst_n)
      (is_r && (imm_fld[5:0] == 6'd42 || imm_fld[5:0] == 6'd43)) |=>
      (res_q[DATA_W-1:1] == '0));

   a_r1_add_wraps: assert property (@(posedge clk) disable iff (!rst_n)
      (is_r && imm_fld[5:0] == 6'd33) |=> (res_q == $past(opa) + $past(opb)));

endmodule

bind int_alu int_alu_checker #(.DATA_W(DATA_W), .IMM_W(IMM_W), .IDX_W(IDX_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .op_major  (op_major),
   .imm_fld   (imm_fld),
   .opa       (opa),
   .opb       (opb),
   .dst_idx   (dst_idx),
   .res_q     (res_q),
   .wr_en_q   (wr_en_q),
   .wr_dst_q  (wr_dst_q),
   .illegal_q (illegal_q)
);

// File: tb/int_alu_tb.sv
module int_alu_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [5:0]  op_major = '0;
   logic [4:0]  sel_fld = '0;
   logic [15:0] imm_fld = '0;
   logic [31:0] opa = '0, opb = '0;
   logic [4:0]  dst_idx = '0;
   logic [31:0] res_q;
   logic        wr_en_q, illegal_q;
   logic [4:0]  wr_dst_q;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   int_alu u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_major(op_major),
      .sel_fld(sel_fld), .imm_fld(imm_fld), .opa(opa), .opb(opb),
      .dst_idx(dst_idx), .res_q(res_q), .wr_en_q(wr_en_q),
      .wr_dst_q(wr_dst_q), .illegal_q(illegal_q)
   );

   function automatic logic [31:0] ror32(input logic [31:0] x, input int n);
      if (n == 0) return x;
      return (x >> n) | (x << (32 - n));
   endfunction

   // Behavioural reference: returns result, write-enable, illegal and a tag.
   function automatic void model(input logic [5:0] op, input logic [4:0] sel,
                                 input logic [15:0] imm, input logic [31:0] a,
                                 input logic [31:0] b, input logic [4:0] dst,
                                 input bit vld, output logic [31:0] r,
                                 output bit we, output bit ill, output string tag);
      int sa = int'(imm[10:6]);
      int va = int'(a[4:0]);
      logic [31:0] sx = {{16{imm[15]}}, imm};
      logic [31:0] zx = {16'h0, imm};
      bit ok = 1'b1;
      r = 32'h0; ill = 1'b0; tag = "R1";
      if (op == 0) begin
         case (imm[5:0])
            0:  begin r = b << sa; tag = "R7"; end
            2:  begin r = (sel == 1) ? ror32(b, sa) : b >> sa; tag = "R7"; end
            3:  begin r = $signed(b) >>> sa; tag = "R7"; end
            4:  begin r = b << va; tag = "R8"; end
            6:  begin r = (sa == 1) ? ror32(b, va) : b >> va; tag = "R8"; end
            7:  begin r = $signed(b) >>> va; tag = "R8"; end
            10: begin r = a; ok = (b == 0); tag = "R6"; end
            11: begin r = a; ok = (b != 0); tag = "R6"; end
            32, 33: r = a + b;
            34, 35: r = a - b;
            36: begin r = a & b; tag = "R2"; end
            37: begin r = a | b; tag = "R2"; end
            38: begin r = a ^ b; tag = "R2"; end
            39: begin r = ~(a | b); tag = "R2"; end
            42: begin r = ($signed(a) < $signed(b)) ? 1 : 0; tag = "R4"; end
            43: begin r = (a < b) ? 1 : 0; tag = "R4"; end
            44: begin r = ($signed(a) > $signed(b)) ? a : b; tag = "R5"; end
            45: begin r = ($signed(a) < $signed(b)) ? a : b; tag = "R5"; end
            default: begin ill = 1'b1; tag = "R10"; end
         endcase
      end else begin
         case (op)
            8, 9: r = a + sx;
            10: begin r = ($signed(a) < $signed(sx)) ? 1 : 0; tag = "R4"; end
            11: begin r = (a < sx) ? 1 : 0; tag = "R4"; end
            12: begin r = a & zx; tag = "R2"; end
            13: begin r = a | zx; tag = "R2"; end
            14: begin r = a ^ zx; tag = "R2"; end
            15: begin r = {imm, 16'h0}; tag = "R3"; end
            default: begin ill = 1'b1; tag = "R10"; end
         endcase
      end
      if (dst == 0 && !ill) tag = "R9";
      if (!vld) begin ill = 1'b0; tag = "R11"; end
      we = vld && !ill && ok && (dst != 0);
   endfunction

   // Drive at a falling edge, compare at the next falling edge.
   task automatic run(input logic [5:0] op, input logic [4:0] sel,
                      input logic [15:0] imm, input logic [31:0] a,
                      input logic [31:0] b, input logic [4:0] dst, input bit vld);
      logic [31:0] er; bit ewe, eill; string tag;
      op_major = op; sel_fld = sel; imm_fld = imm; opa = a; opb = b;
      dst_idx = dst; in_valid = vld;
      model(op, sel, imm, a, b, dst, vld, er, ewe, eill, tag);
      @(negedge clk);
      n_checks++;
      if (wr_en_q !== ewe || illegal_q !== eill || (ewe && res_q !== er) ||
          (ewe && wr_dst_q !== dst)) begin
         n_fail++;
         $display("FAIL %s op=%0d fn=%0d: got res=%h we=%b ill=%b, expected res=%h we=%b ill=%b",
                  tag, op, imm[5:0], res_q, wr_en_q, illegal_q, er, ewe, eill);
      end
   endtask

   function automatic logic [15:0] rfn(input int fn, input int sa);
      return 16'((sa << 6) | fn);
   endfunction

   initial begin
      #2000000;
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: got hang, expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      n_checks++;
      if (res_q !== 0 || wr_en_q !== 0 || illegal_q !== 0 || wr_dst_q !== 0) begin
         n_fail++;
         $display("FAIL R11 reset: got res=%h we=%b ill=%b, expected zeros", res_q, wr_en_q, illegal_q);
      end
      rst_n = 1'b1;
      @(negedge clk);
      // R1 wrap and immediate add
      run(0, 0, rfn(33, 0), 32'h7FFF_FFFF, 32'h1, 3, 1);
      run(0, 0, rfn(32, 0), 32'hFFFF_FFFF, 32'h2, 3, 1);
      run(0, 0, rfn(34, 0), 32'h0, 32'h1, 4, 1);
      run(8, 2, 16'hFFFF, 32'h5, 0, 5, 1);
      run(9, 2, 16'h8000, 32'h0, 0, 5, 1);
      // R2 logic, zero-extended immediates
      run(0, 0, rfn(39, 0), 32'h0F0F_0000, 32'h0000_00FF, 6, 1);
      run(12, 0, 16'hFFFF, 32'hABCD_1234, 0, 6, 1);
      run(13, 0, 16'h8001, 32'h0, 0, 6, 1);
      run(14, 0, 16'hFFFF, 32'hFFFF_FFFF, 0, 6, 1);
      // R3
      run(15, 0, 16'hBEEF, 32'h1234_5678, 0, 7, 1);
      // R4 compares
      run(0, 0, rfn(42, 0), 32'h8000_0000, 32'hFFFF_FFFF, 8, 1);
      run(0, 0, rfn(43, 0), 32'h8000_0000, 32'hFFFF_FFFF, 8, 1);
      run(10, 0, 16'hFFFF, 32'hFFFF_FFFE, 0, 8, 1);
      run(11, 0, 16'hFFFF, 32'hFFFF_FFFE, 0, 8, 1);
      run(11, 0, 16'hFFFF, 32'hFFFF_FFFF, 0, 8, 1);
      // R5
      run(0, 0, rfn(44, 0), 32'hFFFF_FFF0, 32'h3, 9, 1);
      run(0, 0, rfn(45, 0), 32'hFFFF_FFF0, 32'h3, 9, 1);
      run(0, 0, rfn(44, 0), 32'h8000_0000, 32'h8000_0000, 9, 1);
      // R6 conditional moves
      run(0, 0, rfn(10, 0), 32'hCAFE, 32'h0, 10, 1);
      run(0, 0, rfn(10, 0), 32'hCAFE, 32'h1, 10, 1);
      run(0, 0, rfn(11, 0), 32'hCAFE, 32'h0, 10, 1);
      run(0, 0, rfn(11, 0), 32'hCAFE, 32'h8000_0000, 10, 1);
      // R7 immediate shifts and rotate selection
      run(0, 0, rfn(0, 31), 0, 32'h0000_0003, 11, 1);
      run(0, 0, rfn(2, 4), 0, 32'h8000_00F1, 11, 1);
      run(0, 1, rfn(2, 4), 0, 32'h8000_00F1, 11, 1);
      run(0, 2, rfn(2, 4), 0, 32'h8000_00F1, 11, 1);
      run(0, 1, rfn(2, 0), 0, 32'h1234_5678, 11, 1);
      run(0, 0, rfn(3, 31), 0, 32'h8000_0000, 11, 1);
      // R8 variable shifts, wrap and rotate selection
      run(0, 0, rfn(4, 0), 32'd33, 32'h1, 12, 1);
      run(0, 0, rfn(6, 0), 32'd36, 32'hF000_000F, 12, 1);
      run(0, 0, rfn(6, 1), 32'd36, 32'hF000_000F, 12, 1);
      run(0, 0, rfn(6, 2), 32'd4, 32'hF000_000F, 12, 1);
      run(0, 0, rfn(7, 0), 32'd63, 32'h8000_0000, 12, 1);
      // R9 zero destination
      run(0, 0, rfn(33, 0), 32'h1, 32'h1, 0, 1);
      run(15, 0, 16'h1234, 0, 0, 0, 1);
      // R10 illegal encodings
      run(2, 0, 16'h0, 0, 0, 13, 1);
      run(0, 0, rfn(1, 0), 0, 0, 13, 1);
      run(0, 0, rfn(46, 0), 0, 0, 0, 1);
      // R11 idle cycles
      run(0, 0, rfn(33, 0), 32'h1, 32'h1, 14, 0);
      run(2, 0, 16'h0, 0, 0, 14, 0);
      // mixed random stream
      for (int i = 0; i < 2000; i++) begin
         logic [5:0] op;
         int pick = int'($urandom_range(0, 11));
         op = (pick < 4) ? 6'd0 : (pick == 11) ? 6'($urandom_range(16, 63)) : 6'(pick + 4);
         run(op, 5'($urandom_range(0, 2)), 16'($urandom), $urandom,
             ($urandom_range(0, 7) == 0) ? 32'h0 : $urandom,
             5'($urandom), ($urandom_range(0, 9) != 0));
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule